// File: doc/BRIEF.md
# FIFO Level-Crossing Interrupt Unit

This block sits next to the receive and transmit FIFOs of a serial port. It watches the occupancy count of each FIFO. It records four level crossings as sticky status bits, and it drives one level-sensitive interrupt line toward a processor. A status bit is set only in the cycle in which its crossing happens. After that it stays set until software writes a one to its position. Draining or refilling a FIFO never acknowledges an event, so the interrupt handshake is separate from the data handling.

Software sees two four-bit registers through a single-cycle strobe port: an enable mask and the event status. Status bits record events whether they are enabled or not. The mask only decides which recorded events drive the interrupt line. "Half full" means an occupancy of at least `FIFO_DEPTH/2` entries.

Top module: `fifo_event_irq`

## Requirements
- R1: After reset the enable register and the status register read as 0, and `irq` is low.
- R2: Status bit 0 becomes 1 in the cycle after the receive count moves from 0 to any non-zero value.
- R3: Status bit 1 becomes 1 in the cycle after the receive count moves from below `FIFO_DEPTH/2` to `FIFO_DEPTH/2` or more.
- R4: Status bit 2 becomes 1 in the cycle after the transmit count moves from `FIFO_DEPTH/2` or more to below `FIFO_DEPTH/2`.
- R5: Status bit 3 becomes 1 in the cycle after the transmit count moves from non-zero to 0. Crossings in the opposite directions set no bit. One step of the count can set two bits.
- R6: A write to address 1 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R7: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up 1.
- R8: `irq` is high exactly when at least one status bit is 1 whose enable bit (address 0) is also 1.
- R9: Status bits latch whether their enable bit is 0 or 1.
- R10: A status bit stays 1 until it is cleared, even when its FIFO level returns, and it is not set again while a level is only held.
- R11: `reg_rdata` shows the enable register when `reg_addr` is 0 and the status register when `reg_addr` is 1. A write to address 0 loads the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_addr | input | 1 | 0 = enable, 1 = status |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that both occupancy counts are 0 while reset is held, because the crossing detector starts from the view that both FIFOs are empty. They also assume that the counts never exceed `FIFO_DEPTH`. The stimulus holds both counts at zero through reset and only drives values from 0 to `FIFO_DEPTH`, changing them half a cycle away from the clock edge. Several scenarios move a count across both thresholds in a single step, and one lines up a clearing write with a new event so that the priority rule is exercised.

// File: rtl/fei_pkg.sv
// Package for the FIFO level-crossing interrupt unit.
// Holds the event bit positions, the register addresses and the level-flag type.
// Assumes that the register port is exactly one bit per event.
package fei_pkg;
    localparam int NUM_EV        = 4;
    localparam int EV_RX_FILLED  = 0;  // receive FIFO leaves empty
    localparam int EV_RX_HALF    = 1;  // receive FIFO reaches half
    localparam int EV_TX_LOW     = 2;  // transmit FIFO drops below half
    localparam int EV_TX_DRAINED = 3;  // transmit FIFO becomes empty

    localparam logic ADDR_MASK   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    typedef struct packed {
        logic empty;
        logic half;
    } fifo_lvl_t;
endpackage

// File: rtl/fei_level.sv
// Turns a FIFO occupancy count into an empty flag and an at-or-above-half flag.
// Purely combinational. Assumes that the count never exceeds DEPTH.
module fei_level #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    output fei_pkg::fifo_lvl_t lvl
);
    localparam int HALF = DEPTH / 2;

    // derive both level flags from the count
    always_comb begin
        lvl.empty = (count == '0);
        lvl.half  = (count >= CNT_W'(HALF));
    end
endmodule

// File: rtl/fei_edge.sv
// Crossing detector: keeps last cycle's level flags and, by comparing them with
// the current flags, produces one-cycle event pulses. After reset it assumes
// that both FIFOs are empty.
module fei_edge
    import fei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fifo_lvl_t         rx_lvl,
    input  fifo_lvl_t         tx_lvl,
    output logic [NUM_EV-1:0] ev
);
    fifo_lvl_t rx_prev, tx_prev;

    // remember the flags seen in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev <= '{empty: 1'b1, half: 1'b0};
            tx_prev <= '{empty: 1'b1, half: 1'b0};
        end else begin
            rx_prev <= rx_lvl;
            tx_prev <= tx_lvl;
        end
    end

    // compare old and new flags for each watched direction
    always_comb begin
        ev                = '0;
        ev[EV_RX_FILLED]  = rx_prev.empty  && !rx_lvl.empty;
        ev[EV_RX_HALF]    = !rx_prev.half  &&  rx_lvl.half;
        ev[EV_TX_LOW]     = tx_prev.half   && !tx_lvl.half;
        ev[EV_TX_DRAINED] = !tx_prev.empty &&  tx_lvl.empty;
    end
endmodule

// File: rtl/fei_regs.sv
// Register file: holds the enable mask and the sticky status bits.
// Status bits are cleared by writing a one, and a new event wins over a clear
// in the same cycle. The interrupt is the OR of the enabled status bits.
// Reads are combinational. Assumes a single-cycle write strobe.
module fei_regs
    import fei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic              wr,
    input  logic              addr,
    input  logic [NUM_EV-1:0] wdata,
    output logic [NUM_EV-1:0] rdata,
    output logic              irq
);
    logic [NUM_EV-1:0] en_q, st_q, clr;

    // decode the clear mask from a status write
    always_comb clr = (wr && addr == ADDR_STATUS) ? wdata : '0;

    // load the enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr && addr == ADDR_MASK)    en_q <= wdata;
    end

    // one sticky bit per event
    for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
        // set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)      st_q[i] <= 1'b0;
            else if (ev[i])  st_q[i] <= 1'b1;
            else if (clr[i]) st_q[i] <= 1'b0;
        end

        // R10: a set bit holds until it is cleared
        a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $past(st_q[i]) && !$past(clr[i]) |-> st_q[i]);
        // R10: no set without an event
        a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(st_q[i]) && !$past(ev[i]) |-> !st_q[i]);
        // R7: an event always lands, even with a clear
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ev[i]) |-> st_q[i]);
        // R6: a clear without an event empties the bit
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clr[i]) && !$past(ev[i]) |-> !st_q[i]);
    end

    // read mux and interrupt
    always_comb begin
        rdata = (addr == ADDR_MASK) ? en_q : st_q;
        irq   = |(st_q & en_q);
    end
endmodule

// File: rtl/fifo_event_irq.sv
// Top of the FIFO level-crossing interrupt unit. It turns the two occupancy
// counts into level flags, detects the four watched crossings and keeps them
// as sticky, maskable status. Assumes that both counts are 0 during reset and
// never exceed FIFO_DEPTH.
module fifo_event_irq
    import fei_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [NUM_EV-1:0] reg_wdata,
    output logic [NUM_EV-1:0] reg_rdata,
    output logic              irq
);
    localparam int HALF = FIFO_DEPTH / 2;

    fifo_lvl_t         rx_lvl, tx_lvl;
    logic [NUM_EV-1:0] ev;

    fei_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_rx_lvl (.count(rx_count), .lvl(rx_lvl));
    fei_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) i_tx_lvl (.count(tx_count), .lvl(tx_lvl));

    fei_edge i_edge (
        .clk(clk), .rst_n(rst_n), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .ev(ev)
    );

    fei_regs i_regs (
        .clk(clk), .rst_n(rst_n), .ev(ev), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .irq(irq)
    );

    // R2: receive-filled event only on a 0 -> non-zero step
    a_r2_rx_filled: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_RX_FILLED] |-> (rx_count != '0) && ($past(rx_count) == '0));
    // R3: receive-half event only on an upward crossing of half
    a_r3_rx_half: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_RX_HALF] |-> (rx_count >= CNT_W'(HALF)) && ($past(rx_count) < CNT_W'(HALF)));
    // R4: transmit-low event only on a downward crossing of half
    a_r4_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_TX_LOW] |-> (tx_count < CNT_W'(HALF)) && ($past(tx_count) >= CNT_W'(HALF)));
    // R5: transmit-drained event only on a non-zero -> 0 step
    a_r5_tx_drained: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_TX_DRAINED] |-> (tx_count == '0) && ($past(tx_count) != '0));
endmodule

// File: tb/test_fifo_event_irq.sv
`timescale 1ns/1ps
module test_fifo_event_irq;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic          reg_wr = 1'b0, reg_addr = 1'b0;
    logic [3:0]    reg_wdata = '0, reg_rdata;
    logic          irq;
    int            total = 0, bad = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    fifo_event_irq #(.FIFO_DEPTH(DEPTH)) i_fifo_event_irq (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_rx(int v);
        @(negedge clk); rx_count = CW'(v);
        @(negedge clk);
    endtask

    task automatic step_tx(int v);
        @(negedge clk); tx_count = CW'(v);
        @(negedge clk);
    endtask

    task automatic wr_reg(logic a, logic [3:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b1;
    endtask

    task automatic chk_status(string req, logic [3:0] exp);
        reg_addr = 1'b1; #0.1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset;
        reg_addr = 1'b0; #0.1;
        check("R1 enable", reg_rdata, 4'h0);
        chk_status("R1 status", 4'h0);
        check("R1 irq", {3'b0, irq}, 4'h0);
    endtask

    task automatic t_rx_events;
        step_rx(1);
        chk_status("R2 rx filled", 4'h1);
        check("R9 irq masked", {3'b0, irq}, 4'h0);
        step_rx(3);
        chk_status("R10 no new event", 4'h1);
        step_rx(8);
        chk_status("R3 rx half", 4'h3);
        wr_reg(1'b0, 4'h1);
        reg_addr = 1'b0; #0.1;
        check("R11 enable readback", reg_rdata, 4'h1);
        check("R8 irq enabled", {3'b0, irq}, 4'h1);
        step_rx(0);
        chk_status("R10 sticky after drain", 4'h3);
        check("R10 irq held", {3'b0, irq}, 4'h1);
        wr_reg(1'b1, 4'h1);
        chk_status("R6 clear bit0", 4'h2);
        check("R8 irq after ack", {3'b0, irq}, 4'h0);
        wr_reg(1'b1, 4'h0);
        chk_status("R6 zero write", 4'h2);
        wr_reg(1'b1, 4'h2);
        chk_status("R6 clear bit1", 4'h0);
        step_rx(DEPTH);
        chk_status("R2 R3 one step", 4'h3);
        wr_reg(1'b1, 4'h3);
        step_rx(DEPTH);
        chk_status("R10 held level", 4'h0);
        step_rx(0);
    endtask

    task automatic t_tx_events;
        step_tx(10);
        chk_status("R5 upward no event", 4'h0);
        step_tx(7);
        chk_status("R4 tx low", 4'h4);
        step_tx(0);
        chk_status("R5 tx drained", 4'hC);
        wr_reg(1'b0, 4'h4);
        check("R8 irq bit2 enabled", {3'b0, irq}, 4'h1);
        wr_reg(1'b1, 4'h4);
        chk_status("R6 clear bit2", 4'h8);
        check("R8 masked bit3", {3'b0, irq}, 4'h0);
        wr_reg(1'b1, 4'h8);
        step_tx(9);
        step_tx(0);
        chk_status("R4 R5 one step", 4'hC);
        wr_reg(1'b1, 4'hC);
    endtask

    task automatic t_set_wins;
        step_tx(9);
        @(negedge clk);
        tx_count = '0; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 4'hC;
        @(negedge clk); reg_wr = 1'b0;
        chk_status("R7 set beats clear", 4'hC);
        wr_reg(1'b1, 4'hC);
        chk_status("R7 later clear", 4'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx_events();
        t_tx_events();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule